// File: doc/BRIEF.md
# Secondary Bus Rotating Arbiter

This block grants ownership of a shared PCI-style secondary bus. Six external masters each present an active-low request and receive an active-low grant. The bridge that contains the arbiter is a seventh requester, with an active-high request and grant that stay inside the chip. The arbiter watches FRAME# and IRDY# to find the start of each bus transaction. Only a start moves the rotation state, and the master that holds the grant at that moment drops to the bottom of its rotation group.

Two fair schemes are available, chosen by one bit of a small register port. In the split scheme the bridge wins every other transaction, and the six masters take the remaining turns in rotation. In the flat scheme all seven requesters share one ring, with the bridge placed after master 5. If nobody requests, the grant parks on the bridge. A strap input can hand arbitration to an outside arbiter. In that case pair 0 swaps roles: grant pin 0 carries the bridge's request out, and request pin 0 brings the outside grant in.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While `rst` is high, every grant output is deasserted (`mst_gnt_n` all ones, `brg_gnt` low), and a read of address 0x40 returns 0, which selects the split scheme.
- R2: In internal mode at most one grant is asserted in any cycle. When the owner changes, one full cycle with no grant lies between the old grant and the new one.
- R3: In internal mode with no request asserted, `brg_gnt` is asserted by the second rising edge after reset is released.
- R4: After reset the rotation begins at master 0, and the bridge does not hold the priority turn. With everyone requesting, the first grant goes to master 0.
- R5: In the split scheme with all seven requesting, the grant order is master 0, bridge, master 1, bridge, and so on through master 5, bridge, then wraps to master 0.
- R6: In the flat scheme with all seven requesting, the grant order is masters 0 to 5, then the bridge, then master 0 again.
- R7: A write with `cfg_we` high to address 0x40 loads bit 0 of `cfg_wdata` as the scheme bit (1 = flat). Writes to any other address leave it unchanged. `cfg_rdata` shows the bit in bit 0 when `cfg_addr` is 0x40 and is zero for other addresses.
- R8: A master whose request is high is skipped. With only masters 2 and 4 requesting in the split scheme, the grants alternate 2, 4, 2, 4.
- R9: Rotation state changes only on a transaction start. A start is FRAME# low after a cycle in which FRAME# and IRDY# were both high. A requester granted with no start keeps its grant.
- R10: With `cf_strap_n` high, one edge after the inputs change, `mst_gnt_n[0]` equals the inverse of `brg_req`, `brg_gnt` equals the inverse of `mst_req_n[0]`, and `mst_gnt_n[5:1]` stay high whatever `mst_req_n[5:1]` carry.
- R11: No steady requester waits too long between its own grants. In the split scheme a master sees at most 11 other transactions and the bridge at most 1. In the flat scheme each requester sees at most 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cf_strap_n | input | 1 | Low: internal arbiter; high: outside arbiter |
| mst_req_n | input | 6 | Master requests, active low; bit 0 is the outside grant in strap-high mode |
| mst_gnt_n | output | 6 | Master grants, active low; bit 0 is the bridge request out in strap-high mode |
| brg_req | input | 1 | Bridge request, active high |
| brg_gnt | output | 1 | Bridge grant, active high |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |

## Verification
A corrupted rotation pointer or a wrong priority-turn flag shows up at the grant pins on the very next transaction. The bench checks the exact order of every transaction, so such an error is caught within one or two transactions. A wrong owner register shows up at once, either as two grants in one cycle or as a handoff with no idle cycle; a grant monitor watches every cycle for both. A scheme bit that fails to load shows in the read-back and also in the first wrap of the grant order.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    SCHEME_SPLIT = 1'b0,
    SCHEME_FLAT  = 1'b1
  } scheme_e;

  function automatic int ring_next(input int cur, input int len);
    return (cur + 1 >= len) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/sba_mode_reg.sv
module sba_mode_reg #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [7:0] MODE_ADDR = 8'h40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  output logic [DW-1:0]       cfg_rdata,
  output arb_pkg::scheme_e    scheme_o
);
  localparam logic [AW-1:0] ADDR = AW'(MODE_ADDR);
  logic hit;
  logic mode_q;

  assign hit = (cfg_addr == ADDR);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (cfg_we && hit) mode_q <= cfg_wdata[0];
  end

  assign cfg_rdata = hit ? {{(DW-1){1'b0}}, mode_q} : '0;
  assign scheme_o  = arb_pkg::scheme_e'(mode_q);

  // R7: a write to the mode address lands in the scheme bit
  a_r7_mode_load: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && hit) |=> (scheme_o == arb_pkg::scheme_e'($past(cfg_wdata[0]))));
endmodule

// File: rtl/sba_bus_monitor.sv
module sba_bus_monitor (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  output logic start_o
);
  logic idle_q;

  always_ff @(posedge clk) begin
    if (rst) idle_q <= 1'b1;
    else     idle_q <= frame_n & irdy_n;
  end

  assign start_o = idle_q & ~frame_n;
endmodule

// File: rtl/sba_pick.sv
module sba_pick #(
  parameter int NUM_MST = 6,
  parameter int IDX_W   = 3,
  parameter int PTR_W   = 3
) (
  input  logic [NUM_MST-1:0] mst_req_i,
  input  logic               brg_req_i,
  input  arb_pkg::scheme_e   scheme_i,
  input  logic               brg_pri_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic [IDX_W-1:0]   winner_o
);
  localparam int NUM_REQ = NUM_MST + 1;
  localparam logic [IDX_W-1:0] BRG_ID = IDX_W'(NUM_MST);

  logic [NUM_REQ-1:0] all_req;
  assign all_req = {brg_req_i, mst_req_i};

  always_comb begin
    int  idx;
    int  base;
    logic found;
    winner_o = BRG_ID;
    found    = 1'b0;
    idx      = 0;
    base     = 0;
    if (scheme_i == arb_pkg::SCHEME_FLAT) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        idx = (int'(ptr_i) + i) % NUM_REQ;
        if (!found && all_req[idx]) begin
          found    = 1'b1;
          winner_o = IDX_W'(idx);
        end
      end
    end else begin
      if (brg_pri_i && brg_req_i) begin
        found    = 1'b1;
        winner_o = BRG_ID;
      end
      base = (int'(ptr_i) >= NUM_MST) ? 0 : int'(ptr_i);
      for (int i = 0; i < NUM_MST; i++) begin
        idx = (base + i) % NUM_MST;
        if (!found && mst_req_i[idx]) begin
          found    = 1'b1;
          winner_o = IDX_W'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/sba_grant_ctl.sv
module sba_grant_ctl #(
  parameter int NUM_MST = 6,
  parameter int IDX_W   = 3,
  parameter int PTR_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_mode_i,
  input  arb_pkg::scheme_e   scheme_i,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   winner_i,
  input  logic               brg_req_i,
  input  logic               ext_gnt_n_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               brg_pri_o,
  output logic [NUM_MST-1:0] mst_gnt_n_o,
  output logic               brg_gnt_o
);
  localparam int NUM_REQ = NUM_MST + 1;
  localparam logic [IDX_W-1:0] BRG_ID  = IDX_W'(NUM_MST);
  localparam logic [IDX_W-1:0] NONE_ID = IDX_W'(NUM_MST + 1);

  logic [IDX_W-1:0]   owner_q, owner_d;
  logic [PTR_W-1:0]   ptr_q, ptr_nxt;
  logic               brg_pri_q;
  logic [NUM_MST-1:0] gnt_n_q;
  logic               brg_gnt_q;
  logic               ext_q;
  logic               advance;

  always_comb begin
    if (ext_mode_i)               owner_d = NONE_ID;
    else if (owner_q == NONE_ID)  owner_d = winner_i;
    else if (winner_i != owner_q) owner_d = NONE_ID;
    else                          owner_d = owner_q;
  end

  assign advance = start_i && !ext_mode_i && (owner_q != NONE_ID);

  always_comb begin
    if (scheme_i == arb_pkg::SCHEME_FLAT)
      ptr_nxt = PTR_W'(arb_pkg::ring_next(int'(owner_q), NUM_REQ));
    else
      ptr_nxt = PTR_W'(arb_pkg::ring_next(int'(owner_q), NUM_MST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= NONE_ID;
      ptr_q     <= '0;
      brg_pri_q <= 1'b0;
      gnt_n_q   <= '1;
      brg_gnt_q <= 1'b0;
      ext_q     <= 1'b0;
    end else begin
      owner_q <= owner_d;
      ext_q   <= ext_mode_i;
      if (ext_mode_i) begin
        gnt_n_q   <= {{(NUM_MST-1){1'b1}}, ~brg_req_i};
        brg_gnt_q <= ~ext_gnt_n_i;
      end else begin
        for (int k = 0; k < NUM_MST; k++)
          gnt_n_q[k] <= (owner_d != IDX_W'(k));
        brg_gnt_q <= (owner_d == BRG_ID);
      end
      if (advance) begin
        if (owner_q == BRG_ID) begin
          brg_pri_q <= 1'b0;
          if (scheme_i == arb_pkg::SCHEME_FLAT) ptr_q <= '0;
        end else begin
          brg_pri_q <= 1'b1;
          ptr_q     <= ptr_nxt;
        end
      end
    end
  end

  assign ptr_o       = ptr_q;
  assign brg_pri_o   = brg_pri_q;
  assign mst_gnt_n_o = gnt_n_q;
  assign brg_gnt_o   = brg_gnt_q;

  logic [NUM_MST:0] gv;
  assign gv = {brg_gnt_q, ~gnt_n_q};

  // R2: never two owners at once in internal mode
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !ext_q |-> $onehot0(gv));

  // R2: a handoff passes through a cycle with no grant
  a_r2_gap: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && (gv != '0)) |=> (ext_q || (gv == '0) || (gv == $past(gv))));

  // R9: rotation state holds between transaction starts
  a_r9_hold_rotation: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ($stable(ptr_q) && $stable(brg_pri_q)));

  // R10: outside-arbiter mode keeps upper grants high
  a_r10_upper_idle: assert property (@(posedge clk) disable iff (rst)
    ext_mode_i |=> (&gnt_n_q[NUM_MST-1:1]));
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
  parameter int NUM_MST = 6,
  parameter int CFG_AW  = 8,
  parameter int CFG_DW  = 8,
  parameter logic [7:0] MODE_ADDR = 8'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cf_strap_n,
  input  logic [NUM_MST-1:0] mst_req_n,
  output logic [NUM_MST-1:0] mst_gnt_n,
  input  logic               brg_req,
  output logic               brg_gnt,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata
);
  localparam int IDX_W = $clog2(NUM_MST + 2);
  localparam int PTR_W = $clog2(NUM_MST + 1);

  arb_pkg::scheme_e scheme;
  logic             start;
  logic [IDX_W-1:0] winner;
  logic [PTR_W-1:0] ptr;
  logic             brg_pri;
  logic             ext_mode;
  logic [NUM_MST-1:0] req_int;

  assign ext_mode = cf_strap_n;
  assign req_int  = ext_mode ? '0 : ~mst_req_n;

  sba_mode_reg #(.AW(CFG_AW), .DW(CFG_DW), .MODE_ADDR(MODE_ADDR)) u_mode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .scheme_o(scheme)
  );

  sba_bus_monitor u_mon (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .start_o(start)
  );

  sba_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_pick (
    .mst_req_i(req_int), .brg_req_i(brg_req), .scheme_i(scheme),
    .brg_pri_i(brg_pri), .ptr_i(ptr), .winner_o(winner)
  );

  sba_grant_ctl #(.NUM_MST(NUM_MST), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_ctl (
    .clk(clk), .rst(rst), .ext_mode_i(ext_mode), .scheme_i(scheme),
    .start_i(start), .winner_i(winner), .brg_req_i(brg_req),
    .ext_gnt_n_i(mst_req_n[0]), .ptr_o(ptr), .brg_pri_o(brg_pri),
    .mst_gnt_n_o(mst_gnt_n), .brg_gnt_o(brg_gnt)
  );
endmodule

// File: tb/test_sec_bus_arbiter.sv
module test_sec_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cf_strap_n = 1'b0;
  logic [NM-1:0] mst_req_n = '1;
  logic [NM-1:0] mst_gnt_n;
  logic brg_req = 1'b0;
  logic brg_gnt;
  logic frame_n = 1'b1;
  logic irdy_n = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;

  int vectors = 0;
  int fails = 0;
  int mon_fail = 0;
  bit done = 0;
  logic [NM:0] prev_gv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_bus_arbiter i_sec_bus_arbiter (
    .clk(clk), .rst(rst), .cf_strap_n(cf_strap_n), .mst_req_n(mst_req_n),
    .mst_gnt_n(mst_gnt_n), .brg_req(brg_req), .brg_gnt(brg_gnt),
    .frame_n(frame_n), .irdy_n(irdy_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2 monitor: exclusivity and idle cycle on handoff
  always @(negedge clk) begin
    logic [NM:0] gv;
    gv = {brg_gnt, ~mst_gnt_n};
    if (rst || cf_strap_n) prev_gv <= '0;
    else begin
      if ($countones(gv) > 1) begin
        mon_fail++;
        $display("FAIL R2 two grants: actual %0h expected onehot", gv);
      end
      if (prev_gv != '0 && gv != '0 && gv != prev_gv) begin
        mon_fail++;
        $display("FAIL R2 no gap: actual %0h expected 0 after %0h", gv, prev_gv);
      end
      prev_gv <= gv;
    end
  end

  function automatic int granted();
    logic [NM:0] gv;
    gv = {brg_gnt, ~mst_gnt_n};
    if (gv == '0) return -1;
    if ($countones(gv) > 1) return -2;
    for (int i = 0; i <= NM; i++) if (gv[i]) return i;
    return -1;
  endfunction

  function automatic bit wants(input int r);
    if (r == NM) return brg_req;
    return !mst_req_n[r];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_txn(output int who);
    who = -1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (granted() >= 0 && wants(granted())) begin
        who = granted();
        break;
      end
    end
    frame_n = 1'b0; irdy_n = 1'b0;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_fair(input int seq[], input int n, input int bound_m,
                            input int bound_b, input string req);
    for (int r = 0; r <= NM; r++) begin
      int last, worst;
      last = -1; worst = 0;
      for (int i = 0; i < n; i++)
        if (seq[i] == r) begin
          if (last >= 0 && i - last - 1 > worst) worst = i - last - 1;
          last = i;
        end
      check(last >= 0 && worst <= ((r == NM) ? bound_b : bound_m), req,
            "wait bound", worst, (r == NM) ? bound_b : bound_m);
    end
  endtask

  task automatic t_reset_state();
    cf_strap_n = 1'b0; mst_req_n = '1; brg_req = 1'b0;
    rst = 1'b1; cfg_addr = 8'h40;
    repeat (2) @(negedge clk);
    check(mst_gnt_n == '1, "R1", "master grants in reset", mst_gnt_n, 63);
    check(brg_gnt == 1'b0, "R1", "bridge grant in reset", brg_gnt, 0);
    check(cfg_rdata == 8'h00, "R1", "mode in reset", cfg_rdata, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(brg_gnt == 1'b1 && mst_gnt_n == '1, "R3", "park on bridge", brg_gnt, 1);
  endtask

  task automatic t_handoff();
    int g;
    @(negedge clk);
    mst_req_n[3] = 1'b0;
    @(negedge clk);
    g = granted();
    check(g == -1, "R2", "idle cycle on handoff", g, -1);
    @(negedge clk);
    g = granted();
    check(g == 3, "R2", "master 3 after gap", g, 3);
    repeat (5) @(negedge clk);
    g = granted();
    check(g == 3, "R9", "grant held with no start", g, 3);
    mst_req_n[3] = 1'b1;
    repeat (3) @(negedge clk);
    check(brg_gnt == 1'b1, "R3", "re-park on bridge", brg_gnt, 1);
  endtask

  task automatic t_split_all();
    int seq[14];
    int who;
    mst_req_n = '0; brg_req = 1'b1; cf_strap_n = 1'b0;
    do_reset();
    for (int i = 0; i < 14; i++) begin
      do_txn(who);
      seq[i] = who;
      if (i == 0) check(who == 0, "R4", "first owner after reset", who, 0);
      check(who == ((i % 2) ? NM : (i / 2) % NM), "R5", "split order", who,
            (i % 2) ? NM : (i / 2) % NM);
    end
    check_fair(seq, 14, 11, 1, "R11");
    mst_req_n = '1; brg_req = 1'b0;
  endtask

  task automatic t_sparse();
    int who;
    mst_req_n = '1; mst_req_n[2] = 1'b0; mst_req_n[4] = 1'b0; brg_req = 1'b0;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      do_txn(who);
      check(who == ((i % 2) ? 4 : 2), "R8", "skip idle masters", who, (i % 2) ? 4 : 2);
    end
    mst_req_n = '1;
  endtask

  task automatic t_cfg_ignore();
    int who;
    mst_req_n = '1; brg_req = 1'b0;
    do_reset();
    cfg_write(8'h41, 8'h01);
    cfg_write(8'h40, 8'hFE);
    cfg_addr = 8'h40; #1;
    check(cfg_rdata == 8'h00, "R7", "stray writes ignored", cfg_rdata, 0);
    cfg_addr = 8'h41; #1;
    check(cfg_rdata == 8'h00, "R7", "other address reads zero", cfg_rdata, 0);
    @(negedge clk);
    mst_req_n = '0; brg_req = 1'b1;
    do_txn(who);
    do_txn(who);
    check(who == NM, "R7", "still split scheme", who, NM);
    mst_req_n = '1; brg_req = 1'b0;
  endtask

  task automatic t_flat_all();
    int seq[14];
    int who;
    mst_req_n = '1; brg_req = 1'b0;
    do_reset();
    cfg_write(8'h40, 8'h01);
    cfg_addr = 8'h40; #1;
    check(cfg_rdata == 8'h01, "R7", "mode readback", cfg_rdata, 1);
    @(negedge clk);
    mst_req_n = '0; brg_req = 1'b1;
    for (int i = 0; i < 14; i++) begin
      do_txn(who);
      seq[i] = who;
      check(who == i % (NM + 1), "R6", "flat order", who, i % (NM + 1));
    end
    check_fair(seq, 14, 6, 6, "R11");
    mst_req_n = '1; brg_req = 1'b0;
  endtask

  task automatic t_external();
    cf_strap_n = 1'b1; mst_req_n = '1; brg_req = 1'b0;
    do_reset();
    @(negedge clk);
    mst_req_n = '0; brg_req = 1'b1;
    @(negedge clk);
    check(mst_gnt_n == 6'b111110, "R10", "request out on pin 0", mst_gnt_n, 62);
    check(brg_gnt == 1'b1, "R10", "grant in from pin 0", brg_gnt, 1);
    mst_req_n[0] = 1'b1; brg_req = 1'b0;
    @(negedge clk);
    check(mst_gnt_n == 6'b111111, "R10", "request out dropped", mst_gnt_n, 63);
    check(brg_gnt == 1'b0, "R10", "grant in dropped", brg_gnt, 0);
    mst_req_n = '1; cf_strap_n = 1'b0;
    do_reset();
  endtask

  task automatic finish_run();
    check(mon_fail == 0, "R2", "grant monitor errors", mon_fail, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset_state();
    t_handoff();
    t_split_all();
    t_sparse();
    t_cfg_ignore();
    t_flat_all();
    t_external();
    done = 1;
    finish_run();
  end
endmodule